// File: doc/BRIEF.md
# Serial-to-Parallel Latched Display Driver

This block is the logic core of a 32-channel column driver for a display panel. A serial bit is taken in on every falling edge of a slow shift clock and moves through a chain of 32 stages. The last stage goes out on a serial output pin, so several drivers can be chained into one long column. A latch-enable input moves the chain contents into a bank of output latches. While latch enable stays high the latches are transparent, and when it drops they keep what they held.

An output stage sits between the latches and the channel pins. A blanking input forces every channel to one fixed level, and a polarity input inverts every channel. The blanked level depends on polarity: low when polarity is high, high when polarity is low. Everything is timed by one fast system clock. The shift clock is sampled on that clock and its falling edge is detected there. The channel outputs are registered.

Top module: `dd_column_driver`

## Requirements
- R1: A shift occurs only in the system-clock cycle where `shift_clk` is sampled low after being sampled high. On a shift, channel 0 (stage 1) takes `din` and every channel k>0 takes the old value of channel k-1. With no falling edge the chain holds.
- R2: After N=32 shifts the first bit shifted in sits in the last stage, channel 31. `dout` always equals that last stage, with no further delay.
- R3: While `latch_en` is high the latches are transparent: `chan_out` shows the current chain contents one system-clock edge after the chain changes.
- R4: When `latch_en` is low the latches keep the chain contents from the last edge at which `latch_en` was high, and further shifting leaves `chan_out` unchanged.
- R5: With `blank_n`=1 and `pol`=1, each bit of `chan_out` equals its latch bit.
- R6: With `blank_n`=1 and `pol`=0, each bit of `chan_out` is the inverse of its latch bit.
- R7: With `blank_n`=0, `chan_out` is all zeros when `pol`=1 and all ones when `pol`=0.
- R8: `blank_n` and `pol` never alter the chain or latch contents. Once blanking is removed and polarity restored, the earlier pattern returns.
- R9: Synchronous active-high `rst` clears the chain, the latches and `chan_out` to zero, and `dout` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| shift_clk | input | 1 | Shift clock; its falling edge advances the chain |
| din | input | 1 | Serial data in |
| latch_en | input | 1 | High: latches transparent; low: latches hold |
| blank_n | input | 1 | Blanking, active low |
| pol | input | 1 | Polarity; low inverts all channels |
| dout | output | 1 | Last chain stage, used for cascading |
| chan_out | output | 32 | Channel controls, bit k is channel k |

## Verification
The assertions take every input to be synchronous to `clk`. They also assume `shift_clk` stays at each level for at least one system-clock cycle, so that each falling edge is seen exactly once. The bench changes all inputs only on the falling edge of `clk` and holds `shift_clk` high and low for a full cycle each. It never moves `latch_en` low in the same cycle as a shift, so the value captured when the latches close is never in doubt.

// File: rtl/dd_pkg.sv
package dd_pkg;

  // Output-stage mapping for one channel:
  // blanking gates the latch bit to zero, then polarity low inverts.
  function automatic logic chan_drive(input logic lat, input logic blank_n,
                                      input logic pol);
    return (blank_n & lat) ^ ~pol;
  endfunction

endpackage

// File: rtl/dd_shift_reg.sv
module dd_shift_reg #(
  parameter int N = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         shift_clk,
  input  logic         din,
  output logic [N-1:0] sreg,
  output logic         dout
);

  logic sclk_q;
  logic fall;

  always_ff @(posedge clk) begin
    if (rst) sclk_q <= 1'b0;
    else     sclk_q <= shift_clk;
  end

  assign fall = sclk_q & ~shift_clk;

  always_ff @(posedge clk) begin
    if (rst)       sreg <= '0;
    else if (fall) sreg <= {sreg[N-2:0], din};
  end

  assign dout = sreg[N-1];

  AST_HOLD_NO_EDGE: assert property (@(posedge clk) disable iff (rst)
    !fall |=> $stable(sreg)) else $error("chain moved without edge"); // R1

  AST_HEAD_TAKES_DIN: assert property (@(posedge clk) disable iff (rst)
    fall |=> (sreg[0] == $past(din))) else $error("head bit wrong"); // R1

  AST_TAIL_ADVANCE: assert property (@(posedge clk) disable iff (rst)
    fall |=> (dout == $past(sreg[N-2]))) else $error("tail not advanced"); // R2

endmodule

// File: rtl/dd_latch_bank.sv
module dd_latch_bank #(
  parameter int N = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         latch_en,
  input  logic [N-1:0] sreg,
  output logic [N-1:0] view
);

  logic [N-1:0] latch_q;

  always_ff @(posedge clk) begin
    if (rst)           latch_q <= '0;
    else if (latch_en) latch_q <= sreg;
  end

  // Transparent while enabled, stored copy otherwise.
  assign view = latch_en ? sreg : latch_q;

  AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (rst)
    !latch_en |=> $stable(latch_q)) else $error("latch drifted"); // R4

  AST_LATCH_FOLLOW: assert property (@(posedge clk) disable iff (rst)
    latch_en |=> (latch_q == $past(sreg))) else $error("latch missed"); // R3

endmodule

// File: rtl/dd_out_stage.sv
module dd_out_stage
  import dd_pkg::*;
#(
  parameter int N = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] view,
  input  logic         blank_n,
  input  logic         pol,
  output logic [N-1:0] chan_out
);

  for (genvar k = 0; k < N; k++) begin : g_chan
    always_ff @(posedge clk) begin
      if (rst) chan_out[k] <= 1'b0;
      else     chan_out[k] <= chan_drive(view[k], blank_n, pol);
    end
  end

  AST_BLANK_LOW: assert property (@(posedge clk) disable iff (rst)
    (!blank_n && pol) |=> (chan_out == '0)) else $error("blank low"); // R7

  AST_BLANK_HIGH: assert property (@(posedge clk) disable iff (rst)
    (!blank_n && !pol) |=> (&chan_out)) else $error("blank high"); // R7

  AST_PASS_TRUE: assert property (@(posedge clk) disable iff (rst)
    (blank_n && pol) |=> (chan_out == $past(view))) else $error("pass"); // R5

  AST_PASS_INV: assert property (@(posedge clk) disable iff (rst)
    (blank_n && !pol) |=> (chan_out == ~$past(view))) else $error("inv"); // R6

endmodule

// File: rtl/dd_column_driver.sv
module dd_column_driver #(
  parameter int N = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         shift_clk,
  input  logic         din,
  input  logic         latch_en,
  input  logic         blank_n,
  input  logic         pol,
  output logic         dout,
  output logic [N-1:0] chan_out
);

  logic [N-1:0] sreg;
  logic [N-1:0] view;

  dd_shift_reg #(.N(N)) u_shift (
    .clk(clk), .rst(rst), .shift_clk(shift_clk), .din(din),
    .sreg(sreg), .dout(dout)
  );

  dd_latch_bank #(.N(N)) u_latch (
    .clk(clk), .rst(rst), .latch_en(latch_en), .sreg(sreg), .view(view)
  );

  dd_out_stage #(.N(N)) u_out (
    .clk(clk), .rst(rst), .view(view), .blank_n(blank_n), .pol(pol),
    .chan_out(chan_out)
  );

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (chan_out == '0 && dout == 1'b0)) else $error("reset"); // R9

endmodule

// File: tb/sim_dd_column_driver.sv
module sim_dd_column_driver;
  localparam int N = 32;
  localparam time CLK_PERIOD = 10ns;
  localparam int WATCHDOG = 20000;

  logic clk = 0, rst = 1, shift_clk = 0, din = 0, latch_en = 0;
  logic blank_n = 1, pol = 1;
  logic dout;
  logic [N-1:0] chan_out;

  int n_checks = 0, n_fail = 0, cycles = 0;
  bit done = 0;
  logic [N-1:0] model_sr = '0;   // bench's own view of the chain
  logic [N-1:0] model_lat = '0;  // bench's own view of the latches

  dd_column_driver #(.N(N)) u0 (
    .clk(clk), .rst(rst), .shift_clk(shift_clk), .din(din),
    .latch_en(latch_en), .blank_n(blank_n), .pol(pol),
    .dout(dout), .chan_out(chan_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req,
                       input logic [N-1:0] act, input logic [N-1:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [N-1:0] expect_out(input logic [N-1:0] lat);
    if (!blank_n) return pol ? '0 : '1;
    return pol ? lat : ~lat;
  endfunction

  // One shift: high for a cycle, low for a cycle; returns two edges after
  // the shifting edge so that chan_out has also been registered.
  task automatic shift_bit(input logic b);
    @(negedge clk); din = b; shift_clk = 1;
    @(negedge clk); shift_clk = 0;
    @(negedge clk);
    @(negedge clk);
    model_sr = {model_sr[N-2:0], b};
    if (latch_en) model_lat = model_sr;
  endtask

  task automatic t_reset;
    rst = 1; latch_en = 0; blank_n = 1; pol = 1; shift_clk = 0;
    repeat (3) @(negedge clk);
    check(chan_out == '0, "R9 chan_out in reset", chan_out, '0);
    check(dout == 1'b0, "R9 dout in reset", {31'd0, dout}, '0);
    rst = 0; model_sr = '0; model_lat = '0;
    latch_en = 1;
    repeat (2) @(negedge clk);
    check(chan_out == '0, "R9 latches cleared", chan_out, '0);
    latch_en = 0;
  endtask

  task automatic t_shift_transparent;
    logic [N-1:0] pat = 32'hC3A5_1E97;
    latch_en = 1;
    for (int k = 0; k < N; k++) begin
      shift_bit(pat[k]);
      if (k == 0 || k == 7 || k == N-1)
        check(chan_out == model_sr, "R1/R3 transparent follow", chan_out,
              model_sr);
    end
    check(chan_out[N-1] == pat[0], "R2 first bit at last stage",
          {31'd0, chan_out[N-1]}, {31'd0, pat[0]});
    check(dout == pat[0], "R2 dout shows last stage",
          {31'd0, dout}, {31'd0, pat[0]});
    shift_bit(1'b1);
    check(dout == pat[1], "R2 dout after extra shift",
          {31'd0, dout}, {31'd0, pat[1]});
    // No edge: idle cycles must leave outputs alone
    repeat (4) @(negedge clk);
    check(chan_out == model_sr, "R1 hold without edge", chan_out, model_sr);
  endtask

  task automatic t_hold;
    logic [N-1:0] held;
    @(negedge clk); latch_en = 0;
    held = model_lat;
    for (int k = 0; k < 5; k++) shift_bit(k[0]);
    check(chan_out == held, "R4 outputs held while shifting", chan_out, held);
    check(dout == model_sr[N-1], "R2 dout moves while held",
          {31'd0, dout}, {31'd0, model_sr[N-1]});
    @(negedge clk); latch_en = 1;
    @(negedge clk); latch_en = 0; model_lat = model_sr;
    @(negedge clk);
    check(chan_out == model_lat, "R3 pulse loads latches", chan_out,
          model_lat);
  endtask

  task automatic t_polarity;
    for (int m = 0; m < 4; m++) begin
      @(negedge clk); blank_n = m[1]; pol = m[0];
      @(negedge clk);
      check(chan_out == expect_out(model_lat),
            m[1] ? (m[0] ? "R5 pass" : "R6 invert")
                 : (m[0] ? "R7 blank pol=1" : "R7 blank pol=0"),
            chan_out, expect_out(model_lat));
    end
  endtask

  task automatic t_blank_restore;
    @(negedge clk); blank_n = 0; pol = 0;
    for (int k = 0; k < 3; k++) shift_bit(1'b0);
    @(negedge clk); blank_n = 1; pol = 1;
    @(negedge clk);
    check(chan_out == model_lat, "R8 pattern restored", chan_out, model_lat);
    @(negedge clk); latch_en = 1;
    @(negedge clk); latch_en = 0; model_lat = model_sr;
    @(negedge clk);
    check(chan_out == model_sr, "R8 chain intact under blank", chan_out,
          model_sr);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG && !done) begin
      done = 1;
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=%0d expected<=%0d", cycles, WATCHDOG);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks,
               n_fail);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_shift_transparent();
    t_hold();
    t_polarity();
    t_blank_restore();
    t_reset();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks,
               n_fail);
      $finish;
    end
  end

endmodule